// File: doc/BRIEF.md
# Cascaded 5-to-32 Active-Low Line Decoder

This block turns a 5-bit code into 32 select lines, of which at most one is driven low. It serves as a bank or row select where a wide one-hot select is needed and the code arrives in binary. It is purely combinational and holds no state.

The decoder is built in two levels rather than as one flat table. A 2-to-4 bank stage looks at the upper two code bits and pulls one of four bank strobes low. Each strobe opens one of four identical 3-to-8 group decoders. Every group decoder gets the low three code bits in parallel and is gated by three enables: one active high and two active low. One active-low enable of each group takes its bank strobe. The other active-low enable and the active-high enable come from two global inputs that all four groups share. A third global enable, active low, gates the bank stage itself.

Top module: `dec32_cascade`

## Requirements
- R1: With `bank_en_n`=0, `grp_en`=1 and `grp_en_n`=0, exactly one bit of `sel_n` is 0, and its index equals the unsigned value of `code_i`.
- R2: With `bank_en_n`=1, all 32 bits of `sel_n` are 1, whatever the code and the other enables.
- R3: With `grp_en`=0, all 32 bits of `sel_n` are 1, whatever the code and the other enables.
- R4: With `grp_en_n`=1, all 32 bits of `sel_n` are 1, whatever the code and the other enables.
- R5: The low line lies in bank `code_i[4:3]`, which covers lines 8*bank to 8*bank+7. Its position inside the bank equals `code_i[2:0]`, read with bit 2 as the most significant bit.
- R6: The outputs depend only on the present inputs. After other codes and enable patterns, an input pattern seen before gives the same output again.
- R7: Inside the block, at most one bank strobe is low at any time. When `bank_en_n`=0, the strobe for bank `code_i[4:3]` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 5 | Binary code to decode; bits 4:3 pick the bank, bits 2:0 pick the line |
| bank_en_n | input | 1 | Active-low enable of the bank stage |
| grp_en | input | 1 | Active-high enable shared by all four group decoders |
| grp_en_n | input | 1 | Active-low enable shared by all four group decoders |
| sel_n | output | 32 | Active-low one-hot select lines |

## Verification
Two things are decided at the same moment: the bank stage picks a bank from the upper code bits, and the group stage, under the shared enables, picks a line from the lower bits. A wrong line can come from either level. The bench makes both happen at once by driving all 32 codes under all eight enable patterns. It compares every result with a one-hot model that knows nothing of the hierarchy. For each enabled code it then splits the index of the low line into a bank part and a line part, so that a fault can be traced to the level that caused it.

// File: rtl/dec_pkg.sv
// Package dec_pkg
// Shared types for the cascaded decoder. The gate bundle groups the three
// enables that every group decoder receives; helpers evaluate it.
package dec_pkg;

    // Enable bundle of one group decoder: one active-high, two active-low.
    typedef struct packed {
        logic act_hi;
        logic act_lo_a_n;
        logic act_lo_b_n;
    } gate_t;

    // True when all three enables of a bundle are in their active state.
    function automatic logic gate_open(input gate_t g);
        return g.act_hi & ~g.act_lo_a_n & ~g.act_lo_b_n;
    endfunction

endpackage

// File: rtl/dec_bank_pre.sv
// Module dec_bank_pre
// Bank stage: a binary-to-one-hot decoder with an active-low enable and
// active-low outputs. With the enable inactive every output is high.
// Assumes: IN_W is small (the output count is 2**IN_W).
module dec_bank_pre #(
    parameter int IN_W = 2,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  sel_i,
    input  logic             en_n,
    output logic [OUT_N-1:0] y_n
);

    // One comparator per output line, gated by the enable.
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign y_n[k] = ~(~en_n & (sel_i == IN_W'(k)));
    end

endmodule

// File: rtl/dec_group.sv
// Module dec_group
// Group stage: a SEL_W-to-2**SEL_W decoder gated by three enables of mixed
// polarity. Output i goes low only when the select equals i (bit SEL_W-1 is
// the most significant) and the gate bundle is fully open.
// Assumes: SEL_W is small.
module dec_group
    import dec_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    input  gate_t            gate_i,
    output logic [OUT_N-1:0] y_n
);

    logic open_w;

    // Evaluate the three enables once for the whole group.
    assign open_w = gate_open(gate_i);

    // One minterm per output line.
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign y_n[i] = ~(open_w & (sel_i == SEL_W'(i)));
    end

endmodule

// File: rtl/dec32_cascade.sv
// Module dec32_cascade
// Top of the cascaded decoder. The upper BANK_W code bits drive the bank
// stage. Each bank strobe opens one group decoder, which also receives the
// shared enables and the low SEL_W code bits. The group outputs are placed
// side by side so that bank b owns lines b*LINES .. b*LINES+LINES-1.
// Assumes: purely combinational use; no clock or reset.
module dec32_cascade
    import dec_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int SEL_W  = 3,
    localparam int CODE_W = BANK_W + SEL_W,
    localparam int BANKS  = 1 << BANK_W,
    localparam int LINES  = 1 << SEL_W,
    localparam int OUT_N  = BANKS * LINES
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              bank_en_n,
    input  logic              grp_en,
    input  logic              grp_en_n,
    output logic [OUT_N-1:0]  sel_n
);

    logic [BANKS-1:0] bank_sel_n;

    // Bank stage on the upper code bits.
    dec_bank_pre #(.IN_W(BANK_W)) u_bank (
        .sel_i (code_i[CODE_W-1:SEL_W]),
        .en_n  (bank_en_n),
        .y_n   (bank_sel_n)
    );

    // One gated group decoder per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        gate_t gate_w;

        // Bundle the shared enables with this bank's strobe.
        assign gate_w = '{act_hi: grp_en, act_lo_a_n: bank_sel_n[b],
                          act_lo_b_n: grp_en_n};

        dec_group #(.SEL_W(SEL_W)) u_grp (
            .sel_i  (code_i[SEL_W-1:0]),
            .gate_i (gate_w),
            .y_n    (sel_n[b*LINES +: LINES])
        );
    end

endmodule

// File: rtl/dec32_cascade_chk.sv
// Module dec32_cascade_chk
// Checker for dec32_cascade, attached by bind. It holds immediate assertions
// on the top ports and on the bank strobes between the two stages.
// Assumes: the inputs change as a group; checks see settled values.
module dec32_cascade_chk #(
    parameter int BANK_W = 2,
    parameter int SEL_W  = 3,
    localparam int CODE_W = BANK_W + SEL_W,
    localparam int BANKS  = 1 << BANK_W,
    localparam int OUT_N  = BANKS * (1 << SEL_W)
) (
    input logic [CODE_W-1:0] code_i,
    input logic              bank_en_n,
    input logic              grp_en,
    input logic              grp_en_n,
    input logic [BANKS-1:0]  bank_sel_n,
    input logic [OUT_N-1:0]  sel_n
);

    logic all_on;
    assign all_on = ~bank_en_n & grp_en & ~grp_en_n;

    // Check output and strobe rules whenever the inputs settle.
    always_comb begin
        if (all_on) begin
            p_one_low_r1: assert ($countones(~sel_n) == 1)
                else $error("one-hot output broken");
            p_index_r5: assert (sel_n[code_i] == 1'b0)
                else $error("wrong line selected");
        end
        if (bank_en_n) begin
            p_bank_off_r2: assert (&sel_n) else $error("bank enable ignored");
        end
        if (!grp_en) begin
            p_hi_off_r3: assert (&sel_n) else $error("high enable ignored");
        end
        if (grp_en_n) begin
            p_lo_off_r4: assert (&sel_n) else $error("low enable ignored");
        end
        p_strobe_onehot_r7: assert ($onehot0(~bank_sel_n))
            else $error("several bank strobes low");
        if (!bank_en_n) begin
            p_strobe_pick_r7: assert (bank_sel_n[code_i[CODE_W-1:SEL_W]] == 1'b0)
                else $error("wrong bank strobe");
        end
    end

endmodule

bind dec32_cascade dec32_cascade_chk #(.BANK_W(BANK_W), .SEL_W(SEL_W)) u_chk (
    .code_i     (code_i),
    .bank_en_n  (bank_en_n),
    .grp_en     (grp_en),
    .grp_en_n   (grp_en_n),
    .bank_sel_n (bank_sel_n),
    .sel_n      (sel_n)
);

// File: tb/sim_dec32_cascade.sv
// Bench for dec32_cascade: drives inputs after the rising edge, compares
// with a behavioural one-hot model at the falling edge.
module sim_dec32_cascade;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  code;
    logic        bank_en_n, grp_en, grp_en_n;
    logic [31:0] sel_n;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    dec32_cascade u0 (
        .code_i    (code),
        .bank_en_n (bank_en_n),
        .grp_en    (grp_en),
        .grp_en_n  (grp_en_n),
        .sel_n     (sel_n)
    );

    // Reference: integer one-hot, low at the code when fully enabled.
    function automatic logic [31:0] model(int v, logic bn, logic gh, logic gl);
        logic [31:0] e = '1;
        if (!bn && gh && !gl) e[v] = 1'b0;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(int v, logic [2:0] en);
        @(posedge clk);
        #1;
        code      = 5'(v);
        bank_en_n = en[0];
        grp_en    = en[1];
        grp_en_n  = en[2];
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        finish_run();
    end

    initial begin
        code = '0; bank_en_n = 1'b1; grp_en = 1'b0; grp_en_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R2: state while held disabled during reset.
        check("R2 reset", sel_n, '1);
        @(posedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < 8; c++) begin
            for (int v = 0; v < 32; v++) begin
                logic [2:0] en = 3'(c);
                apply(v, en);
                if (en[0])       check("R2 bank off", sel_n, model(v, en[0], en[1], en[2]));
                else if (!en[1]) check("R3 high off", sel_n, model(v, en[0], en[1], en[2]));
                else if (en[2])  check("R4 low off", sel_n, model(v, en[0], en[1], en[2]));
                else begin
                    int idx = -1;
                    check("R1 one-hot", sel_n, model(v, 1'b0, 1'b1, 1'b0));
                    for (int i = 0; i < 32; i++) if (sel_n[i] == 1'b0 && idx < 0) idx = i;
                    // R5: bank part and line part of the low index.
                    check("R5 bank/line", {16'(idx >> 3), 16'(idx & 7)},
                          {16'(v >> 3), 16'(v & 7)});
                end
            end
        end

        // R6: revisit earlier patterns after others.
        apply(5, 3'b010);
        check("R6 repeat a", sel_n, model(5, 1'b0, 1'b1, 1'b0));
        apply(26, 3'b011);
        check("R6 between", sel_n, '1);
        apply(5, 3'b010);
        check("R6 repeat b", sel_n, model(5, 1'b0, 1'b1, 1'b0));
        // R7: each bank reached through its strobe, top line of each bank.
        for (int b = 0; b < 4; b++) begin
            apply(b * 8 + 7, 3'b010);
            check("R7 strobe bank", sel_n, model(b * 8 + 7, 1'b0, 1'b1, 1'b0));
        end

        finish_run();
    end

endmodule